// File: doc/BRIEF.md
# Vector Length Set Unit

This unit carries out the set-vector-length operation of a vector-capable core and owns two control registers: the current vector length and the sub-vector start index. On a strobe it takes an immediate (the amount of register-file space the compiler reserved), a flag saying the source operand is the hardwired zero register, and the source register value. From these it picks a new vector length and stores it. It hands the length back for the destination register with a one-cycle valid pulse, or raises a one-cycle trap when the immediate is out of range.

The length choice is not a plain clamp. A request that exceeds the reservation but is at most twice it is halved, rounding down. A request above twice the reservation jumps to the full machine width XLEN. The start-index register can be loaded directly, for example when execution resumes after a trap. A completion input clears it to zero. A direct load wins over a clear that arrives in the same cycle.

Top module: `vlen_set_unit`

## Requirements
- R1: When a strobe carries an immediate greater than XLEN, `trap` is 1 in the following cycle, `res_valid` stays 0 and the vector length keeps its old value.
- R2: When a legal strobe has `op_src_zero` set, the new vector length equals the immediate.
- R3: When a legal strobe has `op_src_zero` clear and the source value is greater than twice the immediate, the new vector length is XLEN.
- R4: When a legal strobe has `op_src_zero` clear and the source value is greater than the immediate but not greater than twice it, the new vector length is the source value shifted right by one bit.
- R5: When a legal strobe has `op_src_zero` clear and the source value is not greater than the immediate, the new vector length equals the source value.
- R6: One cycle after a legal strobe, `res_valid` is 1 for exactly that cycle and `res_len` holds the new length, zero-extended to XLEN bits. `res_valid` and `trap` are never high together.
- R7: The vector length never exceeds XLEN. The doubled-immediate comparison does not wrap, even for source values near 2^XLEN.
- R8: When `start_wr_en` is 1, the start index takes `start_wr_data` in the following cycle.
- R9: When `done_clr` is 1 and `start_wr_en` is 0, the start index becomes 0 in the following cycle.
- R10: When `start_wr_en` and `done_clr` are both 1, the written value is kept and the clear has no effect.
- R11: After reset, the vector length, start index, `res_valid`, `trap` and `res_len` are all 0.
- R12: In a cycle without a strobe, the vector length does not change and neither `res_valid` nor `trap` pulses in the next cycle, whatever the operand inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Set-length operation strobe |
| op_imm | input | IMM_W | Reserved register space (immediate) |
| op_src_zero | input | 1 | Source operand is the zero register |
| op_src_val | input | XLEN | Source register value (requested length) |
| start_wr_en | input | 1 | Direct load of the start index |
| start_wr_data | input | $clog2(XLEN) | Start index value to load |
| done_clr | input | 1 | Vector instruction completed; clear start index |
| vl_q | output | $clog2(XLEN+1) | Current vector length |
| start_q | output | $clog2(XLEN) | Current start index |
| res_valid | output | 1 | New length available for the destination register |
| res_len | output | XLEN | New length, zero-extended |
| trap | output | 1 | Illegal immediate detected |

## Verification
On every cycle the assertions check the following:
- a trap freezes the length;
- the zero-register and pass-through selections take the right value;
- the length stays at or below XLEN;
- the result pulse carries the stored length;
- idle cycles change nothing;
- the start-index load, clear and priority behave as required.

The full-width and halving branches, including their exact boundaries at the immediate and at twice the immediate, are shown only by the bench. It sweeps every immediate from 0 past XLEN against every source value up to beyond twice XLEN. It also covers source values near 2^XLEN, where a narrow doubling would wrap.

// File: rtl/vlset_pkg.sv
package vlset_pkg;

   // which rule produced the new vector length
   typedef enum logic [1:0] {
      PICK_IMM  = 2'd0,
      PICK_FULL = 2'd1,
      PICK_HALF = 2'd2,
      PICK_PASS = 2'd3
   } vl_pick_e;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/vlset_pick.sv
module vlset_pick
   import vlset_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int IMM_W     = 12,
   parameter int CMP_STYLE = 0,
   localparam int VL_W     = $clog2(XLEN + 1)
) (
   input  logic [IMM_W-1:0] imm,
   input  logic             src_zero,
   input  logic [XLEN-1:0]  src,
   output logic             illegal,
   output logic [VL_W-1:0]  next_vl
);

   // compare width: one bit wider than the widest operand so 2*imm cannot wrap
   localparam int CW = max_i(XLEN, IMM_W) + 1;
   localparam logic [CW-1:0] XLEN_C = CW'(XLEN);

   logic [CW-1:0] imm_w;
   logic [CW-1:0] src_w;
   logic          above_dbl;
   logic          above_imm;
   vl_pick_e      pick;

   assign imm_w = CW'(imm);
   assign src_w = CW'(src);

   assign illegal   = imm_w > XLEN_C;
   assign above_imm = src_w > imm_w;

   generate
      if (CMP_STYLE == 0) begin : g_cmp_wide
         // doubled immediate in the extra bit of headroom
         logic [CW-1:0] imm_dbl;
         assign imm_dbl   = {imm_w[CW-2:0], 1'b0};
         assign above_dbl = src_w > imm_dbl;
      end else begin : g_cmp_half
         // halve the source instead of doubling the immediate
         logic [CW-1:0] src_half;
         assign src_half  = {1'b0, src_w[CW-1:1]};
         assign above_dbl = (src_half > imm_w) ||
                            ((src_half == imm_w) && src_w[0]);
      end
   endgenerate

   always_comb begin
      if (src_zero)       pick = PICK_IMM;
      else if (above_dbl) pick = PICK_FULL;
      else if (above_imm) pick = PICK_HALF;
      else                pick = PICK_PASS;
   end

   always_comb begin
      unique case (pick)
         PICK_IMM:  next_vl = imm_w[VL_W-1:0];
         PICK_FULL: next_vl = XLEN_C[VL_W-1:0];
         PICK_HALF: next_vl = src_w[VL_W:1];
         default:   next_vl = src_w[VL_W-1:0];
      endcase
   end

endmodule

// File: rtl/vlset_len_reg.sv
module vlset_len_reg #(
   parameter int XLEN  = 32,
   localparam int VL_W = $clog2(XLEN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic            illegal,
   input  logic [VL_W-1:0] next_vl,
   output logic [VL_W-1:0] vl_q,
   output logic            res_valid,
   output logic            trap
);

   logic accept;
   assign accept = op_valid && !illegal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vl_q      <= '0;
         res_valid <= 1'b0;
         trap      <= 1'b0;
      end else begin
         res_valid <= accept;
         trap      <= op_valid && illegal;
         if (accept) vl_q <= next_vl;
      end
   end

endmodule

// File: rtl/vlset_start_reg.sv
module vlset_start_reg #(
   parameter int XLEN  = 32,
   localparam int SI_W = $clog2(XLEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [SI_W-1:0] wr_data,
   input  logic            clr,
   output logic [SI_W-1:0] start_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)     start_q <= '0;
      else if (wr_en) start_q <= wr_data;
      else if (clr)   start_q <= '0;
   end

endmodule

// File: rtl/vlen_set_unit.sv
module vlen_set_unit #(
   parameter int XLEN      = 32,
   parameter int IMM_W     = 12,
   parameter int CMP_STYLE = 0,
   localparam int VL_W     = $clog2(XLEN + 1),
   localparam int SI_W     = $clog2(XLEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [IMM_W-1:0] op_imm,
   input  logic             op_src_zero,
   input  logic [XLEN-1:0]  op_src_val,
   input  logic             start_wr_en,
   input  logic [SI_W-1:0]  start_wr_data,
   input  logic             done_clr,
   output logic [VL_W-1:0]  vl_q,
   output logic [SI_W-1:0]  start_q,
   output logic             res_valid,
   output logic [XLEN-1:0]  res_len,
   output logic             trap
);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("vlen_set_unit: XLEN must be 32 or 64");
      end
      if (IMM_W < VL_W || IMM_W >= XLEN) begin : g_bad_imm
         $error("vlen_set_unit: IMM_W must hold XLEN and stay below XLEN bits");
      end
      if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_bad_cmp
         $error("vlen_set_unit: CMP_STYLE must be 0 or 1");
      end
   endgenerate

   logic            illegal;
   logic [VL_W-1:0] next_vl;

   vlset_pick #(
      .XLEN      (XLEN),
      .IMM_W     (IMM_W),
      .CMP_STYLE (CMP_STYLE)
   ) u_pick (
      .imm      (op_imm),
      .src_zero (op_src_zero),
      .src      (op_src_val),
      .illegal  (illegal),
      .next_vl  (next_vl)
   );

   vlset_len_reg #(
      .XLEN (XLEN)
   ) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .illegal   (illegal),
      .next_vl   (next_vl),
      .vl_q      (vl_q),
      .res_valid (res_valid),
      .trap      (trap)
   );

   vlset_start_reg #(
      .XLEN (XLEN)
   ) u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (start_wr_en),
      .wr_data (start_wr_data),
      .clr     (done_clr),
      .start_q (start_q)
   );

   assign res_len = {{(XLEN-VL_W){1'b0}}, vl_q};

endmodule

// File: rtl/vlset_chk.sv
module vlset_chk #(
   parameter int XLEN      = 32,
   parameter int IMM_W     = 12,
   parameter int CMP_STYLE = 0,
   localparam int VL_W     = $clog2(XLEN + 1),
   localparam int SI_W     = $clog2(XLEN)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [IMM_W-1:0] op_imm,
   input logic             op_src_zero,
   input logic [XLEN-1:0]  op_src_val,
   input logic             start_wr_en,
   input logic [SI_W-1:0]  start_wr_data,
   input logic             done_clr,
   input logic [VL_W-1:0]  vl_q,
   input logic [SI_W-1:0]  start_q,
   input logic             res_valid,
   input logic [XLEN-1:0]  res_len,
   input logic             trap
);

   localparam logic [IMM_W:0]  XL_I = (IMM_W + 1)'(XLEN);
   localparam logic [VL_W-1:0] XL_V = VL_W'(XLEN);
   localparam int              CMP_SEL = CMP_STYLE;

   logic bad_imm;
   logic [XLEN-1:0] imm_x;
   assign bad_imm = {1'b0, op_imm} > XL_I;
   assign imm_x   = {{(XLEN-IMM_W){1'b0}}, op_imm};

   a_r1_trap_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && bad_imm |=> trap && !res_valid && $stable(vl_q));

   a_r2_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !bad_imm && op_src_zero |=> vl_q == VL_W'($past(op_imm)));

   a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !bad_imm && !op_src_zero && op_src_val <= imm_x
      |=> vl_q == VL_W'($past(op_src_val)));

   a_r6_result: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !bad_imm |=> res_valid && !trap &&
      res_len == {{(XLEN-VL_W){1'b0}}, vl_q});

   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && trap));

   a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
      vl_q <= XL_V);

   a_r8_write: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr_en |=> start_q == $past(start_wr_data));

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      done_clr && !start_wr_en |=> start_q == '0);

   a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_valid && !trap && $stable(vl_q));

   initial begin
      a_style_ok: assert (CMP_SEL == 0 || CMP_SEL == 1);
   end

endmodule

bind vlen_set_unit vlset_chk #(
   .XLEN      (XLEN),
   .IMM_W     (IMM_W),
   .CMP_STYLE (CMP_STYLE)
) u_chk (.*);

// File: tb/tb_vlen_set_unit.sv
module tb_vlen_set_unit;

   localparam int XLEN  = 32;
   localparam int IMM_W = 7;
   localparam int VL_W  = $clog2(XLEN + 1);
   localparam int SI_W  = $clog2(XLEN);

   logic             clk = 1'b0;
   logic             rst_n;
   logic             op_valid;
   logic [IMM_W-1:0] op_imm;
   logic             op_src_zero;
   logic [XLEN-1:0]  op_src_val;
   logic             start_wr_en;
   logic [SI_W-1:0]  start_wr_data;
   logic             done_clr;
   logic [VL_W-1:0]  vl_q;
   logic [SI_W-1:0]  start_q;
   logic             res_valid;
   logic [XLEN-1:0]  res_len;
   logic             trap;

   int checks = 0;
   int errors = 0;
   longint exp_vl = 0;

   always #2 clk = ~clk;

   vlen_set_unit #(.XLEN(XLEN), .IMM_W(IMM_W)) dut (.*);

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic longint model(input longint imm, input longint src, input bit z);
      if (z) return imm;
      if (src > 2 * imm) return XLEN;
      if (src > imm) return src / 2;
      return src;
   endfunction

   // drive at negedge, sample at the following negedge (one register stage)
   task automatic do_op(input longint imm, input longint src, input bit z);
      string tag;
      op_valid    = 1'b1;
      op_imm      = IMM_W'(imm);
      op_src_val  = XLEN'(src);
      op_src_zero = z;
      @(negedge clk);
      op_valid = 1'b0;
      if (imm > XLEN) begin
         chk("R1 trap", longint'(trap), 1);
         chk("R1 no result", longint'(res_valid), 0);
         chk("R1 vl kept", longint'(vl_q), exp_vl);
      end else begin
         exp_vl = model(imm, src, z);
         if (z) tag = "R2";
         else if (src > 2 * imm) tag = "R3";
         else if (src > imm) tag = "R4";
         else tag = "R5";
         chk(tag, longint'(vl_q), exp_vl);
         chk("R6 valid", longint'(res_valid), 1);
         chk("R6 len", longint'(res_len), exp_vl);
         chk("R6 no trap", longint'(trap), 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; op_valid = 1'b0; op_imm = '0; op_src_zero = 1'b0;
      op_src_val = '0; start_wr_en = 1'b0; start_wr_data = '0; done_clr = 1'b0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 vl", longint'(vl_q), 0);
      chk("R11 start", longint'(start_q), 0);
      chk("R11 valid", longint'(res_valid), 0);
      chk("R11 trap", longint'(trap), 0);
      chk("R11 len", longint'(res_len), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 zero-register source, every legal immediate
      for (int i = 0; i <= XLEN; i++) do_op(i, 77, 1'b1);
      // sweep immediates past XLEN against sources past twice XLEN (R1 R3 R4 R5)
      for (int i = 0; i <= XLEN + 8; i++)
         for (int s = 0; s <= 2 * XLEN + 6; s++) do_op(i, s, 1'b0);
      // R7: source values near 2^XLEN must not wrap the comparison
      do_op(XLEN, 64'hFFFF_FFFF, 1'b0);
      chk("R7 full", longint'(vl_q), XLEN);
      do_op(0, 64'h8000_0000, 1'b0);
      do_op(XLEN, 64'h8000_0001, 1'b0);
      do_op(5, 64'hFFFF_FFFE, 1'b0);
      // R1: largest immediate traps and keeps the length
      do_op(7, 10, 1'b0);
      do_op(127, 3, 1'b0);
      do_op(127, 0, 1'b1);

      // R12: idle cycles with changing operands
      op_imm = 7'd3; op_src_val = 32'd1; op_src_zero = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R12 vl", longint'(vl_q), exp_vl);
      chk("R12 valid", longint'(res_valid), 0);
      chk("R12 trap", longint'(trap), 0);

      // R8 start index load, including the top value
      for (int v = 0; v < XLEN; v += 7) begin
         start_wr_en = 1'b1; start_wr_data = SI_W'(v);
         @(negedge clk);
         start_wr_en = 1'b0;
         chk("R8 load", longint'(start_q), v);
      end
      start_wr_en = 1'b1; start_wr_data = SI_W'(XLEN - 1);
      @(negedge clk);
      start_wr_en = 1'b0;
      chk("R8 load max", longint'(start_q), XLEN - 1);
      // R9 clear
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk("R9 clear", longint'(start_q), 0);
      // R10 load beats clear
      start_wr_en = 1'b1; done_clr = 1'b1; start_wr_data = SI_W'(9);
      @(negedge clk);
      start_wr_en = 1'b0; done_clr = 1'b0;
      chk("R10 priority", longint'(start_q), 9);
      @(negedge clk);
      chk("R10 held", longint'(start_q), 9);
      chk("R8 vl untouched", longint'(vl_q), exp_vl);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule